// File: doc/BRIEF.md
# Direct-Mapped Cache with Deferred Store Writes

This block is the data path of a small direct-mapped cache in which every store completes in one cycle. In the cycle a store arrives, only its tag is checked. If the tag matches, the store is parked in a single deferred-write slot instead of writing the data array. The parked store is written into the array during the tag-check cycle of the next store that hits, so the data array and the tag array are never needed for the same store in the same cycle.

Loads read the tags and the data array in the same cycle. A load whose word address equals the parked store's address takes the parked bytes through a bypass mux, merged byte by byte with the array word. Every store is also passed through to a memory write port, so memory always holds the latest data. A store that misses does not allocate a line. A load that misses starts a line refill from memory. While the refill runs, the block reports busy and ignores requests.

Addresses are word addresses. Offset bits [OFF_W-1:0] select the word within a line, the next IDX_W bits select the line, and the remaining upper bits form the tag.

Top module: `dstore_cache`

## Requirements
- R1: After reset `busy`, `mem_rd_req` and `mem_wr_valid` are 0, no store is parked and every line is invalid, so the first load to any address misses.
- R2: An accepted load whose line is valid and whose tag matches drives `resp_hit`=1 in the same cycle, with the cached word on `resp_rdata`.
- R3: An accepted load that misses drives `resp_hit`=0. From the next cycle `busy` and `mem_rd_req` are 1 and `mem_rd_line` equals the request address without its offset bits. After 2^OFF_W beats of `mem_rd_valid`, each beat filling the next word starting at offset 0, the line is valid and the same load hits.
- R4: An accepted store that hits drives `resp_hit`=1 and is held in the deferred-write slot, and the next request can be accepted in the following cycle.
- R5: A parked store is written into the data array in the cycle of the next store hit, so a later load of its address returns its data from the array after the slot has been reused.
- R6: A load hit whose address equals the parked store's address returns the parked bytes where the parked byte enable is set (enable bit i covers data bits 8i+7..8i) and the array bytes elsewhere.
- R7: A store miss drives `resp_hit`=0, allocates no line and leaves the parked store unchanged, so a later load of the store's address misses.
- R8: Every accepted store drives `mem_wr_valid`=1 in its own cycle, with its address, data and byte enables on the memory write port.
- R9: A load miss whose line index equals the parked store's index discards the parked store, so the store is never written into the refilled line.
- R10: While `busy` is 1, requests are ignored: `resp_hit`=0, `mem_wr_valid`=0, and no cached or parked data changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| resp_hit | output | 1 | Request accepted and tag matched |
| resp_rdata | output | DATA_W | Load data, valid with a load hit |
| busy | output | 1 | Refill in progress, requests ignored |
| mem_wr_valid | output | 1 | Store forwarded to memory |
| mem_wr_addr | output | ADDR_W | Forwarded store address |
| mem_wr_data | output | DATA_W | Forwarded store data |
| mem_wr_be | output | DATA_W/8 | Forwarded store byte enables |
| mem_rd_req | output | 1 | Line refill requested |
| mem_rd_line | output | ADDR_W-OFF_W | Line address being refilled |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | DATA_W | Refill beat data |

## Verification
The bench loads an address right after storing to it. A design without the bypass would return the stale array word. It also does two stores in a row and then loads the first address, which exposes a design that drops the parked store instead of writing it to the array. A partial-enable store followed by a load of the same address checks the byte merge: getting it wrong corrupts the unwritten bytes. The sharpest case parks a store, refills its line with a different tag, and then lets another store hit. A design that keeps the stale slot would write the old store into the new line, and a later load of that line would read wrong data.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned BE_W = DATA_W / 8;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [BE_W-1:0]   be_t;

  // Replace the bytes of base selected by be with those of upd.
  function automatic word_t merge_bytes(word_t base, word_t upd, be_t be);
    word_t r;
    r = base;
    for (int i = 0; i < int'(BE_W); i++)
      if (be[i]) r[8*i +: 8] = upd[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else begin
      if (inv_en) vld[inv_idx] <= 1'b0;
      if (set_en) vld[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (set_en) tags[set_idx] <= set_tag;

  assign lk_hit = vld[lk_idx] && (tags[lk_idx] == lk_tag);

  // R3: a completed refill leaves its line valid
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> vld[$past(set_idx)]);
endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store
  import cwb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  be_t           wbe
);
  localparam int DEPTH = 1 << AW;

  word_t words [DEPTH];

  always_ff @(posedge clk)
    if (we) words[waddr] <= merge_bytes(words[waddr], wdata, wbe);

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/cwb_delay_wr.sv
module cwb_delay_wr
  import cwb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] cap_addr,
  input  word_t         cap_data,
  input  be_t           cap_be,
  input  logic          drop_en,
  input  logic [AW-1:0] lk_addr,
  output logic          vld,
  output logic [AW-1:0] addr,
  output word_t         data,
  output be_t           be,
  output logic          lk_match
);
  always_ff @(posedge clk) begin
    if (!rst_n) vld <= 1'b0;
    else if (cap_en) vld <= 1'b1;
    else if (drop_en) vld <= 1'b0;
  end

  always_ff @(posedge clk)
    if (cap_en) begin
      addr <= cap_addr;
      data <= cap_data;
      be   <= cap_be;
    end

  assign lk_match = vld && (addr == lk_addr);

  // R4: the slot only fills from a store that hit
  a_r4_capture_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> $past(cap_en));
endmodule

// File: rtl/dstore_cache.sv
module dstore_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_store,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_be,
  output logic                    resp_hit,
  output logic [DATA_W-1:0]       resp_rdata,
  output logic                    busy,
  output logic                    mem_wr_valid,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [DATA_W-1:0]       mem_wr_data,
  output logic [DATA_W/8-1:0]     mem_wr_be,
  output logic                    mem_rd_req,
  output logic [ADDR_W-OFF_W-1:0] mem_rd_line,
  input  logic                    mem_rd_valid,
  input  logic [DATA_W-1:0]       mem_rd_data
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  // request fields
  logic [IDX_W-1:0] rq_idx;
  logic [TAG_W-1:0] rq_tag;
  assign rq_idx = req_addr[OFF_W +: IDX_W];
  assign rq_tag = req_addr[ADDR_W-1 -: TAG_W];

  // refill state
  logic              filling;
  logic [LINE_W-1:0] fill_line;
  logic [OFF_W-1:0]  fill_cnt;
  logic              fill_we, fill_last;

  // named internal events
  logic tag_hit, accept, ld_miss, st_hit, st_miss, commit_we, drop_en;
  logic pend_vld, byp_match;
  logic [ADDR_W-1:0] pend_addr;
  word_t pend_data, arr_rd, arr_wdata;
  be_t   pend_be, arr_wbe;
  logic  [ADDR_W-1:0] arr_waddr;

  assign accept  = req_valid && !filling;
  assign ld_miss = accept && !req_store && !tag_hit;
  assign st_hit  = accept && req_store && tag_hit;
  assign st_miss = accept && req_store && !tag_hit;
  assign commit_we = st_hit && pend_vld;
  assign drop_en = ld_miss && pend_vld && (pend_addr[OFF_W +: IDX_W] == rq_idx);
  assign fill_we   = filling && mem_rd_valid;
  assign fill_last = fill_we && (&fill_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling  <= 1'b0;
      fill_cnt <= '0;
    end else if (ld_miss) begin
      filling  <= 1'b1;
      fill_cnt <= '0;
    end else if (fill_we) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (fill_last) filling <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (ld_miss) fill_line <= req_addr[ADDR_W-1:OFF_W];

  cwb_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(rq_idx), .lk_tag(rq_tag), .lk_hit(tag_hit),
    .inv_en(ld_miss), .inv_idx(rq_idx),
    .set_en(fill_last), .set_idx(fill_line[IDX_W-1:0]),
    .set_tag(fill_line[LINE_W-1:IDX_W])
  );

  // array write: refill beat or the deferred store's commit
  always_comb begin
    if (fill_we) begin
      arr_waddr = {fill_line[IDX_W-1:0], fill_cnt};
      arr_wdata = mem_rd_data;
      arr_wbe   = '1;
    end else begin
      arr_waddr = pend_addr;
      arr_wdata = pend_data;
      arr_wbe   = pend_be;
    end
  end

  cwb_data_store #(.AW(IDX_W + OFF_W)) u_data (
    .clk(clk),
    .rd_addr(req_addr[IDX_W+OFF_W-1:0]), .rd_data(arr_rd),
    .we(fill_we || commit_we),
    .waddr(arr_waddr[IDX_W+OFF_W-1:0]),
    .wdata(arr_wdata), .wbe(arr_wbe)
  );

  cwb_delay_wr #(.AW(ADDR_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .cap_en(st_hit), .cap_addr(req_addr), .cap_data(req_wdata), .cap_be(req_be),
    .drop_en(drop_en), .lk_addr(req_addr),
    .vld(pend_vld), .addr(pend_addr), .data(pend_data), .be(pend_be),
    .lk_match(byp_match)
  );

  assign resp_hit   = accept && tag_hit;
  assign resp_rdata = byp_match ? merge_bytes(arr_rd, pend_data, pend_be) : arr_rd;
  assign busy       = filling;

  assign mem_wr_valid = accept && req_store;
  assign mem_wr_addr  = req_addr;
  assign mem_wr_data  = req_wdata;
  assign mem_wr_be    = req_be;
  assign mem_rd_req   = filling;
  assign mem_rd_line  = fill_line;

  // R3: a load miss starts the refill in the next cycle
  a_r3_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ld_miss |=> (busy && mem_rd_req));
  // R9: a refill of the parked store's line empties the slot
  a_r9_drop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |=> !pend_vld);
  // R7: a store miss leaves the parked store untouched
  a_r7_miss_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |=> ($stable(pend_vld) && $stable(pend_addr)));
  // R10: during a refill the slot does not change
  a_r10_busy_freezes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pend_vld) && $stable(pend_addr)));
  // R10: no store leaves the block while busy
  a_r10_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_wr_valid);
endmodule

// File: tb/tb_dstore_cache.sv
module tb_dstore_cache;
  import cwb_pkg::*;

  localparam int ADDR_W = 10, IDX_W = 4, OFF_W = 2;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  word_t req_wdata = '0;
  be_t   req_be = '0;
  logic  resp_hit, busy, mem_wr_valid, mem_rd_req;
  word_t resp_rdata, mem_wr_data;
  logic [ADDR_W-1:0] mem_wr_addr;
  be_t   mem_wr_be;
  logic [LINE_W-1:0] mem_rd_line;
  logic  mem_rd_valid = 0;
  word_t mem_rd_data = '0;

  always #5 clk = ~clk;

  dstore_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_hit(resp_hit), .resp_rdata(resp_rdata), .busy(busy),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .mem_rd_req(mem_rd_req), .mem_rd_line(mem_rd_line),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench memory and line model
  word_t bmem [1 << ADDR_W];
  logic  bvld [1 << IDX_W];
  logic [ADDR_W-IDX_W-OFF_W-1:0] btag [1 << IDX_W];

  function automatic bit model_hit(logic [ADDR_W-1:0] a);
    return bvld[a[OFF_W +: IDX_W]] && btag[a[OFF_W +: IDX_W]] == a[ADDR_W-1 -: (ADDR_W-IDX_W-OFF_W)];
  endfunction

  function automatic word_t apply_be(word_t old, word_t nw, be_t be);
    word_t r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return r;
  endfunction

  // memory refill model
  bit mact = 0;
  int mbeat = 0;
  logic [LINE_W-1:0] mline;
  initial forever begin
    @(negedge clk);
    if (!mact && mem_rd_req) begin
      mact = 1; mbeat = 0; mline = mem_rd_line;
    end else if (mact) begin
      if (mbeat < (1 << OFF_W)) begin
        mem_rd_valid = 1;
        mem_rd_data  = bmem[{mline, mbeat[OFF_W-1:0]}];
        mbeat++;
      end else begin
        mem_rd_valid = 0;
        mact = 0;
      end
    end
  end

  // scoreboard
  typedef struct {
    bit is_store; bit exp_hit; bit exp_wr; word_t exp_data;
    logic [ADDR_W-1:0] addr; word_t wdata; be_t be; string req;
  } item_t;
  item_t q[$];

  initial forever begin
    @(negedge clk);
    #3;
    if (req_valid) begin
      if (q.size() == 0) check(0, "scoreboard empty", 0, 1);
      else begin
        item_t it;
        it = q.pop_front();
        check(resp_hit == it.exp_hit, {it.req, " hit"}, resp_hit, it.exp_hit);
        if (!it.is_store && it.exp_hit)
          check(resp_rdata == it.exp_data, {it.req, " data"}, resp_rdata, it.exp_data);
        if (it.is_store) begin
          check(mem_wr_valid == it.exp_wr, {it.req, " R8 wr_valid"}, mem_wr_valid, it.exp_wr);
          if (it.exp_wr)
            check(mem_wr_addr == it.addr && mem_wr_data == it.wdata && mem_wr_be == it.be,
                  {it.req, " R8 wr fields"}, {mem_wr_addr, mem_wr_data}, {it.addr, it.wdata});
        end
      end
    end
  end

  task automatic issue(input bit st, input logic [ADDR_W-1:0] a, input word_t d,
                       input be_t be, input bit eh, input bit ew, input word_t ed,
                       input string req);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_store = st; req_addr = a; req_wdata = d; req_be = be;
    it.is_store = st; it.exp_hit = eh; it.exp_wr = ew; it.exp_data = ed;
    it.addr = a; it.wdata = d; it.be = be; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input word_t d, input be_t be,
                          input string req);
    bit h;
    h = model_hit(a);
    bmem[a] = apply_be(bmem[a], d, be);
    issue(1, a, d, be, h, 1, '0, req);
  endtask

  // inject: drive an ignored store during the refill (R10)
  task automatic do_load(input logic [ADDR_W-1:0] a, input string req, input bit inject,
                         input logic [ADDR_W-1:0] ia, input word_t idat);
    if (model_hit(a)) begin
      issue(0, a, '0, '0, 1, 0, bmem[a], req);
    end else begin
      issue(0, a, '0, '0, 0, 0, '0, {req, " R3 miss"});
      @(negedge clk);
      req_valid = 0;
      check(busy && mem_rd_req && mem_rd_line == a[ADDR_W-1:OFF_W], "R3 refill request",
            {busy, mem_rd_req, mem_rd_line}, {2'b11, a[ADDR_W-1:OFF_W]});
      if (inject) begin
        item_t it;
        req_valid = 1; req_store = 1; req_addr = ia; req_wdata = idat; req_be = '1;
        it.is_store = 1; it.exp_hit = 0; it.exp_wr = 0; it.exp_data = '0;
        it.addr = ia; it.wdata = idat; it.be = '1; it.req = "R10 ignored store";
        q.push_back(it);
        @(negedge clk);
        req_valid = 0;
      end
      while (busy) @(negedge clk);
      bvld[a[OFF_W +: IDX_W]] = 1;
      btag[a[OFF_W +: IDX_W]] = a[ADDR_W-1 -: (ADDR_W-IDX_W-OFF_W)];
      issue(0, a, '0, '0, 1, 0, bmem[a], {req, " R3 retry"});
    end
  endtask

  localparam logic [ADDR_W-1:0] A = 10'h044, B = 10'h084, C = 10'h0C8, D = 10'h3F0;

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) bmem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0101);
    for (int i = 0; i < (1 << IDX_W); i++) begin bvld[i] = 0; btag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !mem_rd_req && !mem_wr_valid, "R1 reset outputs",
          {busy, mem_rd_req, mem_wr_valid}, 0);

    do_load(A, "R1 R2 cold load", 0, '0, '0);
    do_load(A + 1, "R2 hit other word", 0, '0, '0);
    do_store(A, 32'h1122_3344, 4'hF, "R4 store hit");
    do_load(A, "R6 full bypass", 0, '0, '0);
    do_store(A + 1, 32'hAAAA_BBBB, 4'b0011, "R5 second store commits");
    do_load(A, "R5 committed word", 0, '0, '0);
    do_load(A + 1, "R6 partial merge", 0, '0, '0);
    do_store(D, 32'hDEAD_BEEF, 4'hF, "R7 store miss");
    do_load(A + 1, "R7 slot kept", 0, '0, '0);
    do_load(D, "R7 no allocate", 0, '0, '0);
    do_load(C, "R10 refill C", 0, '0, '0);
    do_load(B, "R9 conflicting refill", 1, C, 32'h0BAD_0BAD);
    do_store(C, 32'hCAFE_F00D, 4'hF, "R9 later store hit");
    do_load(B + 1, "R9 line not corrupted", 0, '0, '0);
    do_store(C + 1, 32'h7777_7777, 4'hF, "R5 commit C");
    do_load(C, "R10 store during busy ignored", 0, '0, '0);
    do_store(C + 2, 32'h0102_0304, 4'hF, "R4 back to back 1");
    do_store(C + 2, 32'hF0F0_0000, 4'b1100, "R4 back to back 2");
    do_load(C + 2, "R6 same-address merge", 0, '0, '0);
    do_load(C + 1, "R5 committed after reuse", 0, '0, '0);
    idle();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule